// File: doc/BRIEF.md
# Key-Committed Boot Window Remap Controller

This block holds the memory-map controls of a small processor subsystem. Software writes the new settings into a pending register. Nothing in the map changes until software writes a fixed key byte to a separate commit register. On that write the pending bits are copied into the active bits, and only the active bits steer the hardware. One of the active bits opens a 2 KB boot window. While it is set, any code fetch or data access that falls inside the window is sent to the boot ROM. The decoder also supplies the offset into the ROM. The other two active bits are passed out to the RAM-area and vector-area mapping logic elsewhere in the chip.

A read-only status register reports the values that are in force, so software can see whether a commit has landed. The boot-window bit is held as a two-state machine, `MAP_OFF` and `MAP_ON`. The transition `T_OPEN` goes from `MAP_OFF` to `MAP_ON` on a key write while the pending boot bit is 1. The transition `T_CLOSE` goes from `MAP_ON` to `MAP_OFF` on a key write while the pending boot bit is 0. Every other cycle takes `T_HOLD` and keeps the state.

Top module: `remap_ctrl`

## Requirements
- R1: After reset the pending and active bits are all 0, neither space selects the boot ROM, and every register reads as 0.
- R2: A write to register address 0 loads bit 0 (boot window), bit 1 (RAM area) and bit 2 (vector area) into the pending copy. The pending copy reads back at address 0 with bits 7 to 3 as 0. The write changes neither the active bits, the status register nor the select outputs.
- R3: A write of 0xD5 to register address 1 copies all three pending bits into the active bits on that clock edge. The access in the same cycle still uses the old mapping, and the next cycle uses the new one.
- R4: A write of any value other than 0xD5 to register address 1 leaves the active bits unchanged.
- R5: While the active boot bit is 1, a code address from 0x1000 to 0x17FF drives `code_rom_sel` high, with `code_rom_off` equal to the address minus 0x1000. A code address outside that range gives a select of 0 and an offset of 0.
- R6: The data-space port follows the same window rule, using `data_rom_sel` and `data_rom_off`, and is decoded independently of the code-space port.
- R7: While the active boot bit is 0, neither select is ever high, whatever the address.
- R8: A read of address 2 returns the status register: bit 0 is the active RAM-area bit, bit 1 is the active vector-area bit, bit 2 is the active boot bit, and bits 7 to 3 are 0. Reads of address 1 and address 3 return 0.
- R9: `map_ram`, `map_vec` and `map_boot` always equal the active RAM-area, vector-area and boot bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 commit key, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| code_addr | input | 16 | Code-space access address |
| data_addr | input | 16 | Data-space access address |
| code_rom_sel | output | 1 | Code access goes to the boot ROM |
| code_rom_off | output | 11 | Boot ROM offset for the code access |
| data_rom_sel | output | 1 | Data access goes to the boot ROM |
| data_rom_off | output | 11 | Boot ROM offset for the data access |
| map_ram | output | 1 | Active RAM-area mapping bit |
| map_vec | output | 1 | Active vector-area mapping bit |
| map_boot | output | 1 | Active boot-window bit |

## Verification
A commit write and a window decode can fall in the same cycle. In that cycle the decode must still follow the old mapping, and the new mapping must appear one cycle later. The bench provokes this by holding window addresses on both access ports while it drives the key write. It checks the selects and offsets just before the clock edge against the model's old active bits. Just after the edge it checks them against the newly committed bits. Random steps mix control writes, key and non-key commits, and window-edge addresses, so the same overlap also comes up without being set up on purpose.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic {
        MAP_OFF = 1'b0,
        MAP_ON  = 1'b1
    } map_state_e;

    typedef struct packed {
        logic vec;
        logic ram;
        logic boot;
    } map_bits_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_KEY  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;

endpackage

// File: rtl/remap_regs.sv
module remap_regs
    import remap_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  KEY    = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  map_bits_t         active,
    output map_bits_t         pending,
    output logic              ctrl_wr,
    output logic              key_hit,
    output logic              key_miss,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int PAD_W = DATA_W - 3;

    logic key_wr;

    assign ctrl_wr  = reg_wr && (reg_addr == REG_CTRL);
    assign key_wr   = reg_wr && (reg_addr == REG_KEY);
    assign key_hit  = key_wr && (reg_wdata[7:0] == KEY);
    assign key_miss = key_wr && (reg_wdata[7:0] != KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (ctrl_wr) begin
            pending.boot <= reg_wdata[0];
            pending.ram  <= reg_wdata[1];
            pending.vec  <= reg_wdata[2];
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_CTRL: reg_rdata = {{PAD_W{1'b0}}, pending.vec, pending.ram, pending.boot};
            REG_STAT: reg_rdata = {{PAD_W{1'b0}}, active.boot, active.vec, active.ram};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/remap_fsm.sv
module remap_fsm
    import remap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  logic      key_hit,
    input  logic      key_miss,
    input  map_bits_t pending,
    output map_bits_t active
);

    map_state_e state_q, state_d;
    logic       ram_q, vec_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_OFF: if (key_hit && pending.boot)  state_d = MAP_ON;
            MAP_ON:  if (key_hit && !pending.boot) state_d = MAP_OFF;
            default: state_d = MAP_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MAP_OFF;
            ram_q   <= 1'b0;
            vec_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (key_hit) begin
                ram_q <= pending.ram;
                vec_q <= pending.vec;
            end
        end
    end

    always_comb begin
        active.boot = (state_q == MAP_ON);
        active.ram  = ram_q;
        active.vec  = vec_q;
    end

    a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> (active == $past(pending)));

    a_r4_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
        key_miss |=> (active == $past(active)));

    a_r2_ctrl_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (active == $past(active)));

endmodule

// File: rtl/remap_window.sv
module remap_window #(
    parameter int          ADDR_W = 16,
    parameter int unsigned BASE   = 32'h1000,
    parameter int unsigned SPAN   = 2048,
    parameter int          OFF_W  = $clog2(SPAN)
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel,
    output logic [OFF_W-1:0]  off
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(SPAN);

    logic [ADDR_W-1:0] delta;
    logic              hit;

    assign delta = addr - BASE_A;
    assign hit   = (addr >= BASE_A) && (delta < SPAN_A);

    always_comb begin
        sel = en && hit;
        off = sel ? delta[OFF_W-1:0] : '0;
    end

endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
    import remap_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter int          DATA_W = 8,
    parameter int unsigned WIN_BASE = 32'h1000,
    parameter int unsigned WIN_SPAN = 2048,
    parameter logic [7:0]  KEY      = 8'hD5,
    localparam int         OFF_W    = $clog2(WIN_SPAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic [ADDR_W-1:0] data_addr,
    output logic              code_rom_sel,
    output logic [OFF_W-1:0]  code_rom_off,
    output logic              data_rom_sel,
    output logic [OFF_W-1:0]  data_rom_off,
    output logic              map_ram,
    output logic              map_vec,
    output logic              map_boot
);

    localparam int NSPACE = 2;

    map_bits_t pending, active;
    logic      ctrl_wr, key_hit, key_miss;

    logic [ADDR_W-1:0] sp_addr [NSPACE];
    logic              sp_sel  [NSPACE];
    logic [OFF_W-1:0]  sp_off  [NSPACE];

    remap_regs #(.DATA_W(DATA_W), .KEY(KEY)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .active    (active),
        .pending   (pending),
        .ctrl_wr   (ctrl_wr),
        .key_hit   (key_hit),
        .key_miss  (key_miss),
        .reg_rdata (reg_rdata)
    );

    remap_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .key_hit  (key_hit),
        .key_miss (key_miss),
        .pending  (pending),
        .active   (active)
    );

    assign sp_addr[0] = code_addr;
    assign sp_addr[1] = data_addr;

    for (genvar g = 0; g < NSPACE; g++) begin : g_space
        remap_window #(
            .ADDR_W (ADDR_W),
            .BASE   (WIN_BASE),
            .SPAN   (WIN_SPAN),
            .OFF_W  (OFF_W)
        ) u_win (
            .en   (active.boot),
            .addr (sp_addr[g]),
            .sel  (sp_sel[g]),
            .off  (sp_off[g])
        );
    end

    assign code_rom_sel = sp_sel[0];
    assign code_rom_off = sp_off[0];
    assign data_rom_sel = sp_sel[1];
    assign data_rom_off = sp_off[1];

    assign map_ram  = active.ram;
    assign map_vec  = active.vec;
    assign map_boot = active.boot;

    a_r7_closed_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !map_boot |-> (!code_rom_sel && !data_rom_sel));

    a_r5_code_sel_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_rom_sel) && $stable(code_addr) |-> $past(key_hit));

endmodule

// File: tb/remap_ctrl_tb.sv
`timescale 1ns/1ps
module remap_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [15:0] code_addr = 16'd0;
    logic [15:0] data_addr = 16'd0;
    logic        code_rom_sel, data_rom_sel;
    logic [10:0] code_rom_off, data_rom_off;
    logic        map_ram, map_vec, map_boot;

    int checks = 0;
    int failures = 0;
    logic [2:0] m_pend = 3'b000;   // {vec, ram, boot}
    logic [2:0] m_act  = 3'b000;

    always #5 clk = ~clk;

    remap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .code_addr(code_addr), .data_addr(data_addr),
        .code_rom_sel(code_rom_sel), .code_rom_off(code_rom_off),
        .data_rom_sel(data_rom_sel), .data_rom_off(data_rom_off),
        .map_ram(map_ram), .map_vec(map_vec), .map_boot(map_boot)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_sel(input logic [15:0] a, input logic boot);
        return boot && (a >= 16'h1000) && (a <= 16'h17FF);
    endfunction

    function automatic int exp_off(input logic [15:0] a, input logic boot);
        return exp_sel(a, boot) ? int'(a - 16'h1000) : 0;
    endfunction

    function automatic int exp_rd(input logic [1:0] ra);
        case (ra)
            2'd0:    return int'(m_pend);
            2'd2:    return int'({m_act[0], m_act[2], m_act[1]});
            default: return 0;
        endcase
    endfunction

    task automatic check_all();
        string dreq;
        dreq = m_act[0] ? "R5" : "R7";
        chk(dreq, int'(code_rom_sel), int'(exp_sel(code_addr, m_act[0])));
        chk(dreq, int'(code_rom_off), exp_off(code_addr, m_act[0]));
        dreq = m_act[0] ? "R6" : "R7";
        chk(dreq, int'(data_rom_sel), int'(exp_sel(data_addr, m_act[0])));
        chk(dreq, int'(data_rom_off), exp_off(data_addr, m_act[0]));
        chk((reg_addr == 2'd0) ? "R2" : "R8", int'(reg_rdata), exp_rd(reg_addr));
        chk("R9", int'({map_vec, map_ram, map_boot}), int'(m_act));
    endtask

    // called at a negedge: apply inputs, check pre-edge, clock, update model
    task automatic step(input logic wr, input logic [1:0] ra, input logic [7:0] wd,
                        input logic [15:0] ca, input logic [15:0] da);
        reg_wr = wr; reg_addr = ra; reg_wdata = wd; code_addr = ca; data_addr = da;
        #1;
        check_all();   // R3: same-cycle access uses the old mapping
        @(posedge clk);
        if (wr && ra == 2'd0) m_pend = wd[2:0];
        if (wr && ra == 2'd1 && wd == 8'hD5) m_act = m_pend;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        code_addr = 16'h1000; data_addr = 16'h1400;
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a); #1;
            chk("R1", int'(reg_rdata), 0);
        end
        chk("R1", int'(code_rom_sel | data_rom_sel), 0);
        chk("R1", int'({map_vec, map_ram, map_boot}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: control write alone changes nothing active
        step(1'b1, 2'd0, 8'hFF, 16'h1000, 16'h17FF);
        step(1'b0, 2'd0, 8'h00, 16'h1000, 16'h17FF);
        chk("R2", int'(reg_rdata), 32'h07);
        chk("R2", int'(code_rom_sel), 0);
        // R4: non-key commit values
        step(1'b1, 2'd1, 8'hD4, 16'h1000, 16'h1000);
        step(1'b1, 2'd1, 8'h55, 16'h1000, 16'h1000);
        step(1'b0, 2'd2, 8'h00, 16'h1000, 16'h1000);
        chk("R4", int'(reg_rdata), 0);
        chk("R4", int'(map_boot), 0);
        // R3: key commit with window addresses held in the same cycle
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'hD5;
        code_addr = 16'h1000; data_addr = 16'h17FF; #1;
        chk("R3", int'(code_rom_sel), 0);
        chk("R3", int'(data_rom_sel), 0);
        @(posedge clk); m_act = m_pend; #1;
        chk("R3", int'(code_rom_sel), 1);
        chk("R3", int'(data_rom_sel), 1);
        chk("R3", int'(data_rom_off), 32'h7FF);
        @(negedge clk); reg_wr = 1'b0;
        // R5/R6: window edges
        step(1'b0, 2'd2, 8'h00, 16'h0FFF, 16'h1800);
        step(1'b0, 2'd2, 8'h00, 16'h17FF, 16'h1000);
        step(1'b0, 2'd2, 8'h00, 16'hFFFF, 16'h1234);
        chk("R8", int'(reg_rdata), 32'h07);
        // R3: close the window again
        step(1'b1, 2'd0, 8'h02, 16'h1100, 16'h1100);
        step(1'b1, 2'd1, 8'hD5, 16'h1100, 16'h1100);
        chk("R7", int'(code_rom_sel | data_rom_sel), 0);
        chk("R8", int'(reg_rdata), 0);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  ra;
            logic [7:0]  wd;
            logic [15:0] ca, da;
            int r;
            r  = $urandom_range(0, 9);
            ra = 2'($urandom_range(0, 3));
            wd = 8'($urandom);
            if (ra == 2'd1 && r < 5) wd = 8'hD5;
            case ($urandom_range(0, 3))
                0: ca = 16'h1000 + 16'($urandom_range(0, 2047));
                1: ca = ($urandom_range(0, 1) != 0) ? 16'h0FFF : 16'h1800;
                2: ca = ($urandom_range(0, 1) != 0) ? 16'h1000 : 16'h17FF;
                default: ca = 16'($urandom);
            endcase
            da = ($urandom_range(0, 1) != 0) ? 16'h1000 + 16'($urandom_range(0, 2047))
                                             : 16'($urandom);
            step(r < 6, ra, wd, ca, da);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule